// File: doc/BRIEF.md
# Converter Conversion Sequencing Controller

This block decides when an external sampled-data converter core samples and converts. A free-running divider turns the fast interface clock into a conversion clock, with the division set by a programmable prescaler. Each conversion opens with a sampling phase. The length of that phase is a programmable number of half conversion-clock periods. At the end of the phase the controller pulses a start strobe to the core and then waits for the core's done strobe. The raw result arrives with that strobe and is captured in a result register.

A conversion can begin in three ways. Software can pulse a start strobe. Another block can pulse an event input. Or the controller keeps converting by itself in free-running mode. In scan mode the controller walks a run of consecutive channels. The first channel is a base channel plus a start offset. A flush input aborts the work in flight, restarts the conversion clock, and samples the same channel again. Three sticky status flags are kept: result ready, window match and overrun. Each flag is cleared by writing a one to it. Reading the result also clears the ready flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: With prescaler setting N (0 to 7), the conversion clock has a period of 2^(N+2) input clocks, so one half period lasts 2^(N+1) input clocks. The divider restarts from zero whenever a sampling phase begins and whenever a flush takes effect.
- R2: `sample_o` stays high for exactly (L+1)·2^(N+1) consecutive input clocks, where L is `cfg_samplen_i`. It is followed in the very next cycle by a one-cycle pulse on `core_start_o`.
- R3: From idle, a one-cycle pulse on either `sw_start_i` or `evt_start_i` starts a conversion, and `sample_o` goes high in the cycle after the pulse. While the controller is busy, both start inputs are ignored and the channel sequence is unaffected.
- R4: With scan disabled, every conversion uses `cfg_base_ch_i` as the channel. When `core_done_i` is seen during a conversion, `core_data_i` appears on `result_o` from the next cycle, and the controller returns to idle unless free-running is enabled.
- R5: With scan enabled, the conversions use the channels base+offset+k for k = 0 up to `cfg_scan_last_i`, in that order. The sum is taken modulo 2^CH_W. After the last channel the controller goes idle when free-running is off.
- R6: With free-running enabled, a new sampling phase begins in the cycle after each accepted done strobe. After the last channel of a scan, the channel returns to base+offset.
- R7: A flush pulse while busy aborts the current sample or conversion. A done strobe that arrives later is ignored and leaves `result_o` unchanged. Sampling then restarts on the same channel, and the scan position is kept.
- R8: `status_o` bit 0 is result ready and is set on each captured result. Bit 1 is window match and is set when `core_win_i` is high with the done strobe. Bit 2 is overrun and is set when a result is captured while bit 0 is still set and `rd_result_i` is low.
- R9: A one in `status_clr_i[i]` clears status bit i, and `rd_result_i` clears bit 0. Bits with a zero in `status_clr_i` are unchanged. When a set and a clear of the same bit fall in the same cycle, the set wins.
- R10: After reset, `status_o`, `result_o`, `busy_o`, `sample_o` and `core_start_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input (interface) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_presc_i | input | PRESC_W | Prescaler setting N; the divide ratio is 2^(N+2) |
| cfg_samplen_i | input | SL_W | Sampling length L; the phase lasts L+1 half periods |
| cfg_free_run_i | input | 1 | Free-running enable |
| cfg_scan_en_i | input | 1 | Scan enable |
| cfg_base_ch_i | input | CH_W | Base channel |
| cfg_offset_i | input | CH_W | Scan start offset |
| cfg_scan_last_i | input | CH_W | Number of scanned channels minus one |
| sw_start_i | input | 1 | Software start strobe |
| evt_start_i | input | 1 | Event start strobe |
| flush_i | input | 1 | Flush strobe |
| core_done_i | input | 1 | Conversion done from the core |
| core_data_i | input | DATA_W | Raw result from the core |
| core_win_i | input | 1 | Window hit qualifier sent with the done strobe |
| rd_result_i | input | 1 | Result read strobe |
| status_clr_i | input | 3 | Write-one-to-clear strobes for the status flags |
| ch_sel_o | output | CH_W | Channel select to the core |
| sample_o | output | 1 | Sampling phase active |
| core_start_o | output | 1 | Conversion start pulse to the core |
| busy_o | output | 1 | Controller not idle |
| result_o | output | DATA_W | Result register |
| status_o | output | 3 | {overrun, window, ready} |

## Verification
The bench measures the width of the sampling window for several prescaler and length pairs. A divider that counts the wrong power of two, or a length that is off by one half period, shows up as a wrong cycle count. It records the channel of every start pulse. From that record it checks the base-plus-offset order of a scan and the wrap back to base+offset in free-running mode. It also checks that a start pulse while busy changes nothing. A flush is placed between a start pulse and its done strobe. The bench then checks that the stale done is dropped and the aborted channel is repeated. A design that accepts the stale done would put the wrong result on `result_o`. The flags are checked for overrun on an unread result, for selective clearing, and for a set beating a clear that is held in the same cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;

  localparam int unsigned FLAG_RDY = 0;
  localparam int unsigned FLAG_WIN = 1;
  localparam int unsigned FLAG_OVR = 2;
  localparam int unsigned FLAG_N   = 3;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned PRESC_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               clr_i,
  output logic               half_tick_o
);
  localparam int unsigned CNT_W = (1 << PRESC_W) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // half period = 2^(N+1) input clocks
  assign mask = (CNT_W'(1) << ({1'b0, presc_i} + (PRESC_W+1)'(1))) - CNT_W'(1);
  assign half_tick_o = ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_tick_o |=> !half_tick_o);
  // R1
  restart_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !half_tick_o);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W = 5,
  parameter int unsigned SL_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            half_tick_i,
  input  logic [SL_W-1:0] cfg_samplen_i,
  input  logic            cfg_free_run_i,
  input  logic            cfg_scan_en_i,
  input  logic [CH_W-1:0] cfg_base_ch_i,
  input  logic [CH_W-1:0] cfg_offset_i,
  input  logic [CH_W-1:0] cfg_scan_last_i,
  input  logic            sw_start_i,
  input  logic            evt_start_i,
  input  logic            flush_i,
  input  logic            core_done_i,
  output logic            div_clr_o,
  output logic            load_o,
  output logic [CH_W-1:0] ch_sel_o,
  output logic            sample_o,
  output logic            core_start_o,
  output logic            busy_o
);
  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] k_q, k_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [SL_W-1:0] hcnt_q, hcnt_d;
  logic            start_q, start_d;
  logic [CH_W-1:0] first_ch;
  logic            more_scan;

  assign first_ch  = cfg_scan_en_i ? (cfg_base_ch_i + cfg_offset_i) : cfg_base_ch_i;
  assign more_scan = cfg_scan_en_i && (k_q != cfg_scan_last_i);

  always_comb begin
    state_d   = state_q;
    k_d       = k_q;
    ch_d      = ch_q;
    hcnt_d    = hcnt_q;
    start_d   = 1'b0;
    div_clr_o = 1'b0;
    load_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sw_start_i || evt_start_i) begin
          state_d   = ST_SAMP;
          k_d       = '0;
          ch_d      = first_ch;
          hcnt_d    = '0;
          div_clr_o = 1'b1;
        end
      end
      ST_SAMP: begin
        if (flush_i) begin
          hcnt_d    = '0;
          div_clr_o = 1'b1;
        end else if (half_tick_i) begin
          if (hcnt_q == cfg_samplen_i) begin
            state_d = ST_CONV;
            start_d = 1'b1;
          end else begin
            hcnt_d = hcnt_q + SL_W'(1);
          end
        end
      end
      ST_CONV: begin
        if (flush_i) begin
          // abort, resample the same channel
          state_d   = ST_SAMP;
          hcnt_d    = '0;
          div_clr_o = 1'b1;
        end else if (core_done_i) begin
          load_o = 1'b1;
          hcnt_d = '0;
          if (more_scan) begin
            state_d   = ST_SAMP;
            k_d       = k_q + CH_W'(1);
            ch_d      = cfg_base_ch_i + cfg_offset_i + k_q + CH_W'(1);
            div_clr_o = 1'b1;
          end else if (cfg_free_run_i) begin
            state_d   = ST_SAMP;
            k_d       = '0;
            ch_d      = first_ch;
            div_clr_o = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      ch_q    <= '0;
      hcnt_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      k_q     <= k_d;
      ch_q    <= ch_d;
      hcnt_q  <= hcnt_d;
      start_q <= start_d;
    end
  end

  assign ch_sel_o     = ch_q;
  assign sample_o     = (state_q == ST_SAMP);
  assign core_start_o = start_q;
  assign busy_o       = (state_q != ST_IDLE);

  // R2
  start_after_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_start_o |-> $past(sample_o));
  // R5
  ch_stable_in_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && $past(sample_o)) |-> $stable(ch_sel_o));
  // R7
  flush_resample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && busy_o) |=> sample_o);
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !sw_start_i && !evt_start_i) |=> !busy_o);
endmodule

// File: rtl/adc_status.sv
module adc_status
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              win_i,
  input  logic              rd_i,
  input  logic [FLAG_N-1:0] clr_i,
  output logic [DATA_W-1:0] result_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic [DATA_W-1:0] result_q;
  logic [FLAG_N-1:0] flags_q, flags_d, set_v, clr_v;

  always_comb begin
    set_v = '0;
    set_v[FLAG_RDY] = load_i;
    set_v[FLAG_WIN] = load_i && win_i;
    set_v[FLAG_OVR] = load_i && flags_q[FLAG_RDY] && !rd_i;
    clr_v = clr_i;
    clr_v[FLAG_RDY] = clr_i[FLAG_RDY] || rd_i;
  end

  // set wins over clear, per bit
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    assign flags_d[i] = set_v[i] || (flags_q[i] && !clr_v[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      flags_q  <= '0;
    end else begin
      if (load_i) result_q <= data_i;
      flags_q <= flags_d;
    end
  end

  assign result_o = result_q;
  assign flags_o  = flags_q;

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flags_o[FLAG_RDY]);
  // R8
  ovr_needs_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[FLAG_OVR]) |-> $past(flags_o[FLAG_RDY]));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W  = 12,
  parameter int unsigned CH_W    = 5,
  parameter int unsigned SL_W    = 6,
  parameter int unsigned PRESC_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] cfg_presc_i,
  input  logic [SL_W-1:0]    cfg_samplen_i,
  input  logic               cfg_free_run_i,
  input  logic               cfg_scan_en_i,
  input  logic [CH_W-1:0]    cfg_base_ch_i,
  input  logic [CH_W-1:0]    cfg_offset_i,
  input  logic [CH_W-1:0]    cfg_scan_last_i,
  input  logic               sw_start_i,
  input  logic               evt_start_i,
  input  logic               flush_i,
  input  logic               core_done_i,
  input  logic [DATA_W-1:0]  core_data_i,
  input  logic               core_win_i,
  input  logic               rd_result_i,
  input  logic [2:0]         status_clr_i,
  output logic [CH_W-1:0]    ch_sel_o,
  output logic               sample_o,
  output logic               core_start_o,
  output logic               busy_o,
  output logic [DATA_W-1:0]  result_o,
  output logic [2:0]         status_o
);
  logic half_tick, div_clr, load;

  adc_clk_div #(.PRESC_W(PRESC_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .presc_i     (cfg_presc_i),
    .clr_i       (div_clr),
    .half_tick_o (half_tick)
  );

  adc_seq_fsm #(.CH_W(CH_W), .SL_W(SL_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .half_tick_i     (half_tick),
    .cfg_samplen_i   (cfg_samplen_i),
    .cfg_free_run_i  (cfg_free_run_i),
    .cfg_scan_en_i   (cfg_scan_en_i),
    .cfg_base_ch_i   (cfg_base_ch_i),
    .cfg_offset_i    (cfg_offset_i),
    .cfg_scan_last_i (cfg_scan_last_i),
    .sw_start_i      (sw_start_i),
    .evt_start_i     (evt_start_i),
    .flush_i         (flush_i),
    .core_done_i     (core_done_i),
    .div_clr_o       (div_clr),
    .load_o          (load),
    .ch_sel_o        (ch_sel_o),
    .sample_o        (sample_o),
    .core_start_o    (core_start_o),
    .busy_o          (busy_o)
  );

  adc_status #(.DATA_W(DATA_W)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .data_i   (core_data_i),
    .win_i    (core_win_i),
    .rd_i     (rd_result_i),
    .clr_i    (status_clr_i),
    .result_o (result_o),
    .flags_o  (status_o)
  );

  // R4
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_done_i |=> $stable(result_o));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12, CH_W = 5, SL_W = 6, PRESC_W = 3;
  localparam int NV = 5;
  localparam logic [2:0]      V_PRESC [NV] = '{3'd0, 3'd1, 3'd2, 3'd0, 3'd7};
  localparam logic [SL_W-1:0] V_LEN   [NV] = '{6'd0, 6'd3, 6'd1, 6'd5, 6'd0};
  localparam logic [CH_W-1:0] V_BASE  [NV] = '{5'd1, 5'd2, 5'd7, 5'd31, 5'd2};

  logic clk = 0, rst_n = 0;
  logic [PRESC_W-1:0] presc = '0;
  logic [SL_W-1:0] samplen = '0;
  logic free_run = 0, scan_en = 0;
  logic [CH_W-1:0] base = '0, offs = '0, last = '0;
  logic sw = 0, evt = 0, flush = 0, rd = 0;
  logic [2:0] clr = '0;
  logic done = 0, win;
  logic [DATA_W-1:0] cdata;
  logic [CH_W-1:0] ch_sel, s_ch = '0;
  logic sample, cstart, busy;
  logic [DATA_W-1:0] result;
  logic [2:0] status;
  int s_cnt = 0;
  int n_chk = 0, n_fail = 0;
  logic [CH_W-1:0] log_ch [32];
  int log_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_ctrl #(.DATA_W(DATA_W), .CH_W(CH_W), .SL_W(SL_W), .PRESC_W(PRESC_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_presc_i(presc), .cfg_samplen_i(samplen),
    .cfg_free_run_i(free_run), .cfg_scan_en_i(scan_en), .cfg_base_ch_i(base),
    .cfg_offset_i(offs), .cfg_scan_last_i(last), .sw_start_i(sw), .evt_start_i(evt),
    .flush_i(flush), .core_done_i(done), .core_data_i(cdata), .core_win_i(win),
    .rd_result_i(rd), .status_clr_i(clr), .ch_sel_o(ch_sel), .sample_o(sample),
    .core_start_o(cstart), .busy_o(busy), .result_o(result), .status_o(status));

  // behavioural converter core: done three cycles after start
  assign cdata = DATA_W'(12'h800) | DATA_W'(s_ch);
  assign win   = (s_ch == 5'd2);
  always @(posedge clk) begin
    if (cstart) begin
      s_cnt <= 3; s_ch <= ch_sel; done <= 1'b0;
      if (log_n < 32) log_ch[log_n] <= ch_sel;
      log_n <= log_n + 1;
    end else if (s_cnt == 1) begin
      s_cnt <= 0; done <= 1'b1;
    end else begin
      if (s_cnt > 1) s_cnt <= s_cnt - 1;
      done <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sw();
    @(negedge clk) sw = 1; @(negedge clk) sw = 0;
  endtask
  task automatic pulse_evt();
    @(negedge clk) evt = 1; @(negedge clk) evt = 0;
  endtask
  task automatic pulse_rd();
    @(negedge clk) rd = 1; @(negedge clk) rd = 0;
  endtask
  task automatic pulse_clr(input logic [2:0] m);
    @(negedge clk) clr = m; @(negedge clk) clr = '0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w, mark;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(status == 3'b0 && result == '0, "R10", int'(status), 0);
    chk(!busy && !sample && !cstart, "R10", int'({busy, sample, cstart}), 0);
    rst_n = 1;
    @(negedge clk);

    // vector table: R1/R2 widths, R3 start sources, R4 result, R8 window
    for (int v = 0; v < NV; v++) begin
      presc = V_PRESC[v]; samplen = V_LEN[v]; base = V_BASE[v];
      if (v % 2 == 0) pulse_sw(); else pulse_evt();
      chk(sample == 1'b1, "R3", int'(sample), 1);
      w = 0;
      for (int i = 0; i < 20000 && sample; i++) begin w++; @(negedge clk); end
      chk(w == (int'(V_LEN[v]) + 1) * (1 << (int'(V_PRESC[v]) + 1)), "R2", w,
          (int'(V_LEN[v]) + 1) * (1 << (int'(V_PRESC[v]) + 1)));
      chk(cstart == 1'b1, "R2", int'(cstart), 1);
      wait_idle();
      chk(result == (12'h800 | 12'(V_BASE[v])), "R4", int'(result), int'(12'h800 | 12'(V_BASE[v])));
      chk(status[0] == 1'b1, "R8", int'(status[0]), 1);
      chk(status[1] == (V_BASE[v] == 5'd2), "R8", int'(status[1]), int'(V_BASE[v] == 5'd2));
      pulse_rd();
      pulse_clr(3'b010);
      chk(status == 3'b000, "R9", int'(status), 0);
    end

    // scan with flush and a busy trigger: R5 R7 R3
    presc = 3'd1; samplen = 6'd1; scan_en = 1; base = 5'd3; offs = 5'd0; last = 5'd2;
    mark = log_n;
    pulse_sw();
    repeat (2) @(negedge clk);
    pulse_evt();
    for (int i = 0; i < 2000 && log_n < mark + 2; i++) @(negedge clk);
    flush = 1; @(negedge clk) flush = 0;
    repeat (5) @(negedge clk);
    chk(result == 12'h803, "R7", int'(result), 12'h803);
    chk(sample == 1'b1, "R7", int'(sample), 1);
    wait_idle();
    chk(log_n - mark == 4, "R7", log_n - mark, 4);
    chk(log_ch[mark] == 5'd3 && log_ch[mark+1] == 5'd4, "R5", int'(log_ch[mark+1]), 4);
    chk(log_ch[mark+2] == 5'd4, "R7", int'(log_ch[mark+2]), 4);
    chk(log_ch[mark+3] == 5'd5, "R5", int'(log_ch[mark+3]), 5);
    chk(result == 12'h805, "R5", int'(result), 12'h805);
    pulse_clr(3'b111);

    // free-running scan with wrap: R6, overrun R8, selective clear R9
    presc = 3'd0; samplen = 6'd0; base = 5'd4; offs = 5'd1; last = 5'd1; free_run = 1;
    mark = log_n;
    pulse_sw();
    for (int i = 0; i < 2000 && log_n < mark + 5; i++) @(negedge clk);
    free_run = 0;
    wait_idle();
    chk(log_n - mark == 6, "R6", log_n - mark, 6);
    for (int i = 0; i < 6; i++)
      chk(log_ch[mark+i] == ((i % 2 == 0) ? 5'd5 : 5'd6), "R6", int'(log_ch[mark+i]),
          (i % 2 == 0) ? 5 : 6);
    chk(status == 3'b101, "R8", int'(status), 5);
    pulse_clr(3'b100);
    chk(status == 3'b001, "R9", int'(status), 1);
    pulse_rd();
    chk(status == 3'b000, "R9", int'(status), 0);

    // set beats a clear held in the same cycle: R9
    scan_en = 0; base = 5'd2;
    @(negedge clk) rd = 1; clr = 3'b010;
    pulse_sw();
    for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
    @(negedge clk);
    chk(status == 3'b011, "R9", int'(status), 3);
    @(negedge clk);
    chk(status == 3'b000, "R9", int'(status), 0);
    rd = 0; clr = '0;
    wait_idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule